// File: doc/BRIEF.md
# Split Product Register Unit

This block stores a multiplier result as four 16-bit parts: a low part, two partial middle parts and a high part. The two middle parts are not merged when written. They are added together only when the product is read. The block presents two combinational outputs:

- the full 40-bit two's-complement product rebuilt from the four parts;
- a rounded copy of that product, which adds 0x7FFF and then clears the low 16 bits.

A datapath can load a complete 40-bit product in one cycle. That load spreads the value over the parts and zeroes the second middle part. Any single 16-bit part can also be written on its own. The multiplier and any accumulator logic are outside this block.

Top module: `split_prod_unit`

## Requirements
- R1: While reset (`rst_n` low) is applied, all four parts are zero, so both `prod_o` and `rnd_o` read 0.
- R2: `prod_o` = (high[7:0] sign-extended, shifted left 32) + ((mid + mid2) shifted left 16) + low, kept to 40 bits as two's complement. A carry out of the middle sum reaches bit 32.
- R3: `rnd_o` = (`prod_o` + 0x7FFF) with bits 15:0 then forced to 0, kept to 40 bits.
- R4: A full load (`ld_en`=1) puts `ld_val[15:0]` in low, `ld_val[31:16]` in mid and `ld_val[39:32]` in high. After the next edge, `prod_o` equals `ld_val`.
- R5: A full load zeroes mid2, whatever value mid2 held before.
- R6: With `wr_en`=1, `wr_sel` picks the part that takes `wr_data`: 0 low, 1 mid, 2 mid2, 3 high. Bits 15:8 of the high part have no effect on either output.
- R7: When `ld_en` and `wr_en` are both high in the same cycle, only the full load takes effect.
- R8: With `ld_en`=0 and `wr_en`=0, both outputs hold their value across clock edges, whatever `wr_data`, `wr_sel` and `ld_val` carry.
- R9: Loads and writes show on the outputs only after the next rising clock edge. Before that edge, the outputs keep their old value.
- R10: Any carry beyond bit 39 is dropped, both in the product and in the rounding. For example, a product of 0x7F_FFFF_8001 rounds to 0x80_0000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_en | input | 1 | Load a full 40-bit product |
| ld_val | input | 40 | Product value to load |
| wr_en | input | 1 | Write one 16-bit part |
| wr_sel | input | 2 | Part select: 0 low, 1 mid, 2 mid2, 3 high |
| wr_data | input | 16 | Data for the selected part |
| prod_o | output | 40 | Combined signed product |
| rnd_o | output | 40 | Rounded product |

## Verification
Part-by-part writes are swept over a grid of corner values. The low part straddles the rounding threshold (0x7FFF, 0x8000, 0x8001), which separates round-down, tie and round-up behaviour. Pairs of middle values whose sum overflows 16 bits show whether the middle carry reaches the high byte. High values with junk in the upper byte and with either sign show whether only the sign-extended low byte is used. Full loads with a nonzero mid2 left over, loads issued together with writes, and values next to the 40-bit wrap separate the clearing, precedence and truncation rules from one another.

// File: rtl/split_prod_pkg.sv
package split_prod_pkg;

    localparam int PART_W  = 16;
    localparam int HI_W    = 8;
    localparam int PROD_W  = 2 * PART_W + HI_W;
    localparam int SEL_W   = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_LO   = 2'd0,
        SEL_MID  = 2'd1,
        SEL_MID2 = 2'd2,
        SEL_HI   = 2'd3
    } part_sel_e;

    typedef struct packed {
        logic [PART_W-1:0] lo;
        logic [PART_W-1:0] mid;
        logic [PART_W-1:0] mid2;
        logic [PART_W-1:0] hi;
    } prod_parts_t;

endpackage

// File: rtl/split_prod_regs.sv
module split_prod_regs
    import split_prod_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [PROD_W-1:0] ld_val,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [PART_W-1:0] wr_data,
    output prod_parts_t       parts_o
);

    localparam int HI_PAD = PART_W - HI_W;

    prod_parts_t parts_d;
    prod_parts_t parts_q;

    // Next-state: a full load takes priority over a single-part write.
    always_comb begin
        parts_d = parts_q;
        if (ld_en) begin
            parts_d.lo   = ld_val[PART_W-1:0];
            parts_d.mid  = ld_val[2*PART_W-1:PART_W];
            parts_d.mid2 = '0;
            parts_d.hi   = {{HI_PAD{ld_val[PROD_W-1]}}, ld_val[PROD_W-1:2*PART_W]};
        end else if (wr_en) begin
            unique case (part_sel_e'(wr_sel))
                SEL_LO:   parts_d.lo   = wr_data;
                SEL_MID:  parts_d.mid  = wr_data;
                SEL_MID2: parts_d.mid2 = wr_data;
                SEL_HI:   parts_d.hi   = wr_data;
                default:  parts_d      = parts_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            parts_q <= '0;
        end else begin
            parts_q <= parts_d;
        end
    end

    assign parts_o = parts_q;

endmodule

// File: rtl/split_prod_combine.sv
module split_prod_combine
    import split_prod_pkg::*;
(
    input  prod_parts_t       parts_i,
    output logic [PROD_W-1:0] prod_o
);

    localparam int SUM_W  = PART_W + 1;
    localparam int LO_PAD = PROD_W - PART_W;
    localparam int SM_PAD = PROD_W - SUM_W - PART_W;

    logic [SUM_W-1:0]  mid_sum;
    logic [PROD_W-1:0] hi_term;
    logic [PROD_W-1:0] mid_term;
    logic [PROD_W-1:0] lo_term;

    always_comb begin
        mid_sum  = {1'b0, parts_i.mid} + {1'b0, parts_i.mid2};
        // Sign extension of the high byte lies wholly above bit PROD_W-1,
        // so only the low HI_W bits of the high part reach the result.
        hi_term  = {parts_i.hi[HI_W-1:0], {(2*PART_W){1'b0}}};
        mid_term = {{SM_PAD{1'b0}}, mid_sum, {PART_W{1'b0}}};
        lo_term  = {{LO_PAD{1'b0}}, parts_i.lo};
        prod_o   = hi_term + mid_term + lo_term;
    end

endmodule

// File: rtl/split_prod_round.sv
module split_prod_round
    import split_prod_pkg::*;
#(
    parameter int RND_BITS = PART_W
) (
    input  logic [PROD_W-1:0] prod_i,
    output logic [PROD_W-1:0] rnd_o
);

    localparam logic [PROD_W-1:0] BIAS = PROD_W'((64'd1 << (RND_BITS - 1)) - 64'd1);
    localparam logic [PROD_W-1:0] KEEP = ~PROD_W'((64'd1 << RND_BITS) - 64'd1);

    logic [PROD_W-1:0] biased;

    always_comb begin
        biased = prod_i + BIAS;
        rnd_o  = biased & KEEP;
    end

endmodule

// File: rtl/split_prod_unit.sv
module split_prod_unit
    import split_prod_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [39:0]       ld_val,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [15:0]       wr_data,
    output logic [39:0]       prod_o,
    output logic [39:0]       rnd_o
);

    prod_parts_t       parts;
    logic [PROD_W-1:0] prod_w;
    logic [PROD_W-1:0] rnd_w;

    split_prod_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (ld_en),
        .ld_val  (ld_val),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .parts_o (parts)
    );

    split_prod_combine u_comb (
        .parts_i (parts),
        .prod_o  (prod_w)
    );

    split_prod_round #(.RND_BITS(PART_W)) u_rnd (
        .prod_i (prod_w),
        .rnd_o  (rnd_w)
    );

    assign prod_o = prod_w;
    assign rnd_o  = rnd_w;

endmodule

// File: rtl/split_prod_chk.sv
module split_prod_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ld_en,
    input logic [39:0] ld_val,
    input logic        wr_en,
    input logic [1:0]  wr_sel,
    input logic [15:0] wr_data,
    input logic [39:0] prod_o,
    input logic [39:0] rnd_o
);

    logic signed [39:0] rnd_gap;
    assign rnd_gap = rnd_o - prod_o;

    // R4 R5 R7
    property load_lands_p;
        @(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ld_en)) |-> (prod_o == $past(ld_val));
    endproperty
    load_lands_chk: assert property (load_lands_p);

    // R3
    property rnd_low_zero_p;
        @(posedge clk) disable iff (!rst_n)
        rnd_o[15:0] == 16'h0;
    endproperty
    rnd_low_zero_chk: assert property (rnd_low_zero_p);

    // R3
    property rnd_gap_p;
        @(posedge clk) disable iff (!rst_n)
        (rnd_gap >= -40'sd32768) && (rnd_gap <= 40'sd32767);
    endproperty
    rnd_gap_chk: assert property (rnd_gap_p);

    // R8
    property idle_hold_p;
        @(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ld_en) && !$past(wr_en)) |-> ($stable(prod_o) && $stable(rnd_o));
    endproperty
    idle_hold_chk: assert property (idle_hold_p);

    // R6
    property lo_write_p;
        @(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && !$past(ld_en) && ($past(wr_sel) == 2'd0))
            |-> (prod_o[15:0] == $past(wr_data));
    endproperty
    lo_write_chk: assert property (lo_write_p);

endmodule

bind split_prod_unit split_prod_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (ld_en),
    .ld_val  (ld_val),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .prod_o  (prod_o),
    .rnd_o   (rnd_o)
);

// File: tb/split_prod_unit_test.sv
module split_prod_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [39:0] ld_val = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [39:0] prod_o;
    logic [39:0] rnd_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // bench's own copy of the four parts
    logic [15:0] m_lo = '0, m_mid = '0, m_mid2 = '0, m_hi = '0;

    always #5 clk = ~clk;

    split_prod_unit uut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_val(ld_val),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .prod_o(prod_o), .rnd_o(rnd_o)
    );

    function automatic logic [39:0] want_prod();
        logic [63:0] acc;
        acc = {{24{m_hi[7]}}, m_hi[7:0], 32'h0};
        acc = acc + ((64'(m_mid) + 64'(m_mid2)) << 16);
        acc = acc + 64'(m_lo);
        return acc[39:0];
    endfunction

    function automatic logic [39:0] want_rnd(input logic [39:0] p);
        logic [63:0] t;
        t = 64'(p) + 64'h7FFF;
        t = (t / 64'h10000) * 64'h10000;
        return t[39:0];
    endfunction

    task automatic check(input string tag, input logic [39:0] got, input logic [39:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic check_both(input string tag);
        logic [39:0] p;
        p = want_prod();
        check({tag, " prod"}, prod_o, p);
        check({tag, " rnd"}, rnd_o, want_rnd(p));
    endtask

    task automatic write_part(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (sel)
            2'd0: m_lo = d;
            2'd1: m_mid = d;
            2'd2: m_mid2 = d;
            default: m_hi = d;
        endcase
    endtask

    task automatic load_full(input logic [39:0] v);
        @(negedge clk);
        ld_en = 1'b1; ld_val = v;
        @(negedge clk);
        ld_en = 1'b0;
        m_lo = v[15:0]; m_mid = v[31:16]; m_mid2 = '0;
        m_hi = {{8{v[39]}}, v[39:32]};
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lo_set [6] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'h8001, 16'hFFFF};
        logic [15:0] md_set [4] = '{16'h0000, 16'h0001, 16'h8000, 16'hFFFF};
        logic [15:0] hi_set [5] = '{16'h0000, 16'hA57F, 16'h0080, 16'h00FF, 16'h5A12};
        logic [39:0] ld_set [8] = '{40'h00_0000_0000, 40'h12_3456_789A, 40'h7F_FFFF_8001,
                                    40'hFF_FFFF_FFFF, 40'h80_0000_0000, 40'h00_0000_8000,
                                    40'hC3_8000_7FFF, 40'h7F_FFFF_FFFF};
        logic [39:0] held;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 prod", prod_o, 40'h0);
        check("R1 rnd", rnd_o, 40'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R6: sweep over part corner values
        foreach (lo_set[a]) foreach (md_set[b]) foreach (md_set[c]) foreach (hi_set[d]) begin
            write_part(2'd0, lo_set[a]);
            write_part(2'd1, md_set[b]);
            write_part(2'd2, md_set[c]);
            write_part(2'd3, hi_set[d]);
            check_both("R2/R3/R6 sweep");
        end

        // R6: upper byte of high part ignored
        write_part(2'd3, 16'h0042);
        held = prod_o;
        write_part(2'd3, 16'hFF42);
        check("R6 hi upper byte", prod_o, held);

        // R4 R10: full loads including wrap cases
        foreach (ld_set[i]) begin
            load_full(ld_set[i]);
            check("R4 load", prod_o, ld_set[i]);
            check("R10 rnd", rnd_o, want_rnd(ld_set[i]));
        end
        load_full(40'h7F_FFFF_8001);
        check("R10 wrap up", rnd_o, 40'h80_0000_0000);
        load_full(40'hFF_FFFF_FFFF);
        check("R10 wrap zero", rnd_o, 40'h00_0000_0000);

        // R10: middle carry beyond bit 39 dropped
        write_part(2'd1, 16'hFFFF);
        write_part(2'd2, 16'h0001);
        check("R10 mid carry", prod_o, 40'h00_0000_FFFF);

        // R5: load clears mid2
        write_part(2'd2, 16'h1234);
        load_full(40'h01_0002_0003);
        check("R5 mid2 cleared", prod_o, 40'h01_0002_0003);

        // R7: load wins over a simultaneous write
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_val = 40'h05_0A0B_0C0D;
            wr_en = 1'b1; wr_sel = 2'(s); wr_data = 16'hBEEF;
            @(negedge clk);
            ld_en = 1'b0; wr_en = 1'b0;
            check("R7 load priority", prod_o, 40'h05_0A0B_0C0D);
        end
        m_lo = 16'h0C0D; m_mid = 16'h0A0B; m_mid2 = '0; m_hi = 16'h0005;

        // R9: no change before the edge, change after
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 16'h7777;
        #1;
        check("R9 before edge", prod_o, 40'h05_0A0B_0C0D);
        @(negedge clk);
        wr_en = 1'b0;
        m_lo = 16'h7777;
        check("R9 after edge", prod_o, 40'h05_0A0B_7777);

        // R8: idle with busy data lines
        held = prod_o;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            wr_data = 16'(k * 16'h1111); wr_sel = 2'(k); ld_val = {5{8'(k)}};
        end
        @(negedge clk);
        check("R8 hold prod", prod_o, held);
        check("R8 hold rnd", rnd_o, want_rnd(held));

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule